// File: doc/BRIEF.md
# Flash Sector Protection Sequencer

This block sits on the host side of a parallel NOR-style flash bus. It protects one sector per request. A start pulse carries a sector number. The sequencer then issues a setup write and a protect write, both with command 0x60. It waits a programmable number of cycles while the flash programs its protection cells. Next it writes the verify command 0x40 and reads one word back.

Bit 0 of that word reports the result. If the bit is high, the sector is protected. If it is low, the sequencer sends the protect write again, up to a retry limit. In both cases the operation ends with a pulse on the flash reset line, which takes the device out of the protection mode. After that pulse the block raises a one-cycle done pulse on success or a one-cycle fail pulse when the limit is used up.

Every command address has the same layout. The sector number sits on the upper address bits, starting at bit `SECT_LSB`. Address bits 6, 1 and 0 carry the pattern 0, 1, 0. All other bits are low.

Top module: `sector_guard_seq`

## Requirements
- R1: While `rstN` is low and after it is released, `busy`, `doneP` and `failP` are 0, and `flashWeN`, `flashOeN` and `flashRstN` are all 1.
- R2: An accepted start issues a setup write of data 0x0060, followed by a protect write of data 0x0060. Both use address `(sector << SECT_LSB) | 0x2`: bit 1 is high, bits 6 and 0 are low, and all other bits outside the sector field are low.
- R3: Every write holds `flashWeN` low for exactly `WE_CYC` consecutive cycles. Address and data stay stable while it is low and for one cycle after it returns high.
- R4: After each protect write, `flashWeN` stays high for at least `WAIT_CYC` cycles. The verify write of data 0x0040 to the same address follows.
- R5: Each verify write is followed by a read in which `flashOeN` is low for exactly `RD_CYC` cycles. Only bit 0 of the word read decides the outcome.
- R6: When bit 0 reads low, the next write is another protect write (0x0060), not a setup write. At most `MAX_TRY` protect writes occur per operation.
- R7: When bit 0 reads high, `flashRstN` goes low for exactly `RST_CYC` cycles. `doneP` is then high for one cycle, in the cycle right after `flashRstN` returns high.
- R8: When the `MAX_TRY`-th verify still reads bit 0 low, the same reset pulse follows, and then `failP` is high for one cycle instead of `doneP`.
- R9: `busy` is high from the cycle after an accepted start through the cycle of the done or fail pulse. A start request seen while `busy` is high is ignored, and that includes the cycle of the done or fail pulse.
- R10: `flashWeN` and `flashOeN` are never low together, and `flashRstN` is low only while both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start request, sampled when idle |
| sectorIn | input | SECT_W | Sector number captured with the start request |
| busy | output | 1 | High while an operation runs |
| doneP | output | 1 | One-cycle pulse: sector confirmed protected |
| failP | output | 1 | One-cycle pulse: retry limit reached |
| flashAddr | output | ADDR_W | Flash address bus |
| flashDout | output | DATA_W | Write data to the flash |
| flashDin | input | DATA_W | Read data from the flash |
| flashWeN | output | 1 | Active-low write enable |
| flashOeN | output | 1 | Active-low output enable |
| flashRstN | output | 1 | Active-low flash reset |

## Verification
Two events can fall in the same cycle: a fresh start request and the done pulse that closes the previous operation. The bench raises `startReq` in exactly the cycle where `doneP` is seen. It then checks that `busy` stays low and that no write strobe appears for many cycles afterwards.

The retry counter reaching its limit can also coincide with a verify read. The bench sets the flash model to confirm protection only on the final allowed try, and separately never. It then judges whether a done pulse or a fail pulse follows the reset pulse.

// File: rtl/sguard_pkg.sv
package sguard_pkg;
  localparam logic [7:0] CMD_PROTECT = 8'h60;
  localparam logic [7:0] CMD_VERIFY  = 8'h40;

  typedef struct packed {
    logic loadSector;
    logic busOn;
    logic verifyCmd;
    logic capture;
  } sgStrobe_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SETUP, ST_PROT, ST_WAIT, ST_VERIFY,
    ST_READ, ST_RESET, ST_DONE, ST_FAIL
  } sgState_t;
endpackage

// File: rtl/sguard_dp.sv
module sguard_dp
  import sguard_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 16,
  parameter int SECT_W   = 7,
  parameter int SECT_LSB = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  sgStrobe_t         strobe,
  input  logic [SECT_W-1:0] sectorIn,
  input  logic [DATA_W-1:0] flashDin,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [DATA_W-1:0] flashDout,
  output logic              okBit
);
  localparam logic [ADDR_W-1:0] LOW_PATTERN = ADDR_W'(2);

  logic [SECT_W-1:0] sectorReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sectorReg <= '0;
      okBit     <= 1'b0;
    end else begin
      if (strobe.loadSector) sectorReg <= sectorIn;
      if (strobe.capture)    okBit     <= flashDin[0];
    end
  end

  always_comb begin
    flashAddr = '0;
    flashDout = '0;
    if (strobe.busOn) begin
      flashAddr = (ADDR_W'(sectorReg) << SECT_LSB) | LOW_PATTERN;
      flashDout = DATA_W'(strobe.verifyCmd ? CMD_VERIFY : CMD_PROTECT);
    end
  end
endmodule

// File: rtl/sguard_ctrl.sv
module sguard_ctrl
  import sguard_pkg::*;
#(
  parameter int WE_CYC   = 4,
  parameter int RD_CYC   = 2,
  parameter int WAIT_CYC = 50000,
  parameter int MAX_TRY  = 25,
  parameter int RST_CYC  = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      okBit,
  output sgStrobe_t strobe,
  output logic      busy,
  output logic      doneP,
  output logic      failP,
  output logic      flashWeN,
  output logic      flashOeN,
  output logic      flashRstN
);
  localparam int M1      = (WE_CYC > RD_CYC) ? WE_CYC : RD_CYC;
  localparam int M2      = (M1 > RST_CYC) ? M1 : RST_CYC;
  localparam int CNT_MAX = (M2 > WAIT_CYC) ? M2 : WAIT_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int TRY_W   = $clog2(MAX_TRY + 1);

  sgState_t          state;
  logic [CNT_W-1:0]  cnt;
  logic [TRY_W-1:0]  tryCnt;
  logic              passFlag;
  logic              inWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      tryCnt   <= '0;
      passFlag <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (startReq) begin
            state  <= ST_SETUP;
            tryCnt <= '0;
          end
        end
        ST_SETUP: if (cnt == CNT_W'(WE_CYC)) begin
          state <= ST_PROT;
          cnt   <= '0;
        end
        ST_PROT: if (cnt == CNT_W'(WE_CYC)) begin
          state  <= ST_WAIT;
          cnt    <= '0;
          tryCnt <= tryCnt + 1'b1;
        end
        ST_WAIT: if (cnt == CNT_W'(WAIT_CYC - 1)) begin
          state <= ST_VERIFY;
          cnt   <= '0;
        end
        ST_VERIFY: if (cnt == CNT_W'(WE_CYC)) begin
          state <= ST_READ;
          cnt   <= '0;
        end
        ST_READ: if (cnt == CNT_W'(RD_CYC - 1)) begin
          cnt <= '0;
          if (okBit) begin
            state    <= ST_RESET;
            passFlag <= 1'b1;
          end else if (tryCnt == TRY_W'(MAX_TRY)) begin
            state    <= ST_RESET;
            passFlag <= 1'b0;
          end else begin
            state <= ST_PROT;
          end
        end
        ST_RESET: if (cnt == CNT_W'(RST_CYC - 1)) begin
          state <= passFlag ? ST_DONE : ST_FAIL;
          cnt   <= '0;
        end
        ST_DONE, ST_FAIL: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    inWrite           = (state == ST_SETUP) || (state == ST_PROT) || (state == ST_VERIFY);
    flashWeN          = !(inWrite && (cnt < CNT_W'(WE_CYC)));
    flashOeN          = (state != ST_READ);
    flashRstN         = (state != ST_RESET);
    busy              = (state != ST_IDLE);
    doneP             = (state == ST_DONE);
    failP             = (state == ST_FAIL);
    strobe.loadSector = (state == ST_IDLE) && startReq;
    strobe.busOn      = inWrite || (state == ST_WAIT) || (state == ST_READ);
    strobe.verifyCmd  = (state == ST_VERIFY);
    strobe.capture    = (state == ST_READ) && (cnt == CNT_W'(RD_CYC - 2));
  end
endmodule

// File: rtl/sector_guard_seq.sv
module sector_guard_seq
  import sguard_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 16,
  parameter int SECT_W   = 7,
  parameter int SECT_LSB = 12,
  parameter int WE_CYC   = 4,
  parameter int RD_CYC   = 2,
  parameter int WAIT_CYC = 50000,
  parameter int MAX_TRY  = 25,
  parameter int RST_CYC  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [SECT_W-1:0] sectorIn,
  output logic              busy,
  output logic              doneP,
  output logic              failP,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [DATA_W-1:0] flashDout,
  input  logic [DATA_W-1:0] flashDin,
  output logic              flashWeN,
  output logic              flashOeN,
  output logic              flashRstN
);
  sgStrobe_t strobe;
  logic      okBit;

  sguard_ctrl #(
    .WE_CYC(WE_CYC), .RD_CYC(RD_CYC), .WAIT_CYC(WAIT_CYC),
    .MAX_TRY(MAX_TRY), .RST_CYC(RST_CYC)
  ) ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .okBit(okBit),
    .strobe(strobe), .busy(busy), .doneP(doneP), .failP(failP),
    .flashWeN(flashWeN), .flashOeN(flashOeN), .flashRstN(flashRstN)
  );

  sguard_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W), .SECT_LSB(SECT_LSB)
  ) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sectorIn(sectorIn),
    .flashDin(flashDin), .flashAddr(flashAddr), .flashDout(flashDout),
    .okBit(okBit)
  );
endmodule

// File: rtl/sguard_checker.sv
module sguard_checker #(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 16,
  parameter int WAIT_CYC = 50000
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              doneP,
  input logic              failP,
  input logic [ADDR_W-1:0] flashAddr,
  input logic [DATA_W-1:0] flashDout,
  input logic              flashWeN,
  input logic              flashOeN,
  input logic              flashRstN
);
  int gapCnt;

  always_ff @(posedge clk) begin
    if (!rstN)          gapCnt <= 0;
    else if (!flashWeN) gapCnt <= 0;
    else if (gapCnt < WAIT_CYC + 2) gapCnt <= gapCnt + 1;
  end

  assert_we_oe_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(!flashWeN && !flashOeN));
  assert_rst_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !flashRstN |-> (flashWeN && flashOeN));
  assert_bus_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    !flashWeN |=> ($stable(flashAddr) && $stable(flashDout)));
  assert_verify_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(flashWeN) && flashDout == DATA_W'(8'h40)) |-> (gapCnt >= WAIT_CYC));
  assert_done_after_rst_R7: assert property (@(posedge clk) disable iff (!rstN)
    doneP |-> !$past(flashRstN));
  assert_fail_after_rst_R8: assert property (@(posedge clk) disable iff (!rstN)
    failP |-> !$past(flashRstN));
  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(doneP && failP));
  assert_pulse_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (doneP || failP) |=> (!busy && !doneP && !failP));
endmodule

bind sector_guard_seq sguard_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_CYC(WAIT_CYC)
) chk (
  .clk(clk), .rstN(rstN), .busy(busy), .doneP(doneP), .failP(failP),
  .flashAddr(flashAddr), .flashDout(flashDout), .flashWeN(flashWeN),
  .flashOeN(flashOeN), .flashRstN(flashRstN)
);

// File: tb/sector_guard_seq_test.sv
`timescale 1ns/1ps
module sector_guard_seq_test;
  localparam int ADDR_W = 19, DATA_W = 16, SECT_W = 7, SECT_LSB = 12;
  localparam int WE_CYC = 3, RD_CYC = 2, WAIT_CYC = 20, MAX_TRY = 3, RST_CYC = 4;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wrItem_t;

  logic clk = 0, rstN = 0, startReq = 0;
  logic [SECT_W-1:0] sectorIn = '0;
  logic busy, doneP, failP, flashWeN, flashOeN, flashRstN;
  logic [ADDR_W-1:0] flashAddr;
  logic [DATA_W-1:0] flashDout, flashDin;

  int total = 0, bad = 0;
  wrItem_t expQ[$];
  int needProt = 1, protCount = 0, writeIdx = 0;
  int weLow = 0, oeLow = 0, rstLow = 0, gapHigh = 0;
  logic prevWeN = 1, prevOeN = 1, prevRstN = 1;

  always #2.5 clk = ~clk;

  sector_guard_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W), .SECT_LSB(SECT_LSB),
    .WE_CYC(WE_CYC), .RD_CYC(RD_CYC), .WAIT_CYC(WAIT_CYC),
    .MAX_TRY(MAX_TRY), .RST_CYC(RST_CYC)
  ) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .sectorIn(sectorIn),
    .busy(busy), .doneP(doneP), .failP(failP), .flashAddr(flashAddr),
    .flashDout(flashDout), .flashDin(flashDin), .flashWeN(flashWeN),
    .flashOeN(flashOeN), .flashRstN(flashRstN)
  );

  // flash model: upper bit set to show only bit 0 matters (R5)
  assign flashDin = (!flashOeN && protCount >= needProt) ? 16'h8001 : 16'h8000;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected writes and times each bus phase
  always @(negedge clk) begin
    if (rstN) begin
      if (!flashWeN && prevWeN) begin
        wrItem_t got, exp;
        got = '{addr: flashAddr, data: flashDout};
        if (flashDout == 16'h0040)
          check(gapHigh >= WAIT_CYC, "R4", "gap before verify", gapHigh, WAIT_CYC);
        if (expQ.size() == 0) begin
          check(0, "R9", "unexpected write", got, 0);
        end else begin
          exp = expQ.pop_front();
          check(got == exp, (exp.data == 16'h0040) ? "R4" : "R2", "write item", got, exp);
        end
        if (flashDout == 16'h0060 && writeIdx > 0) protCount++;
        writeIdx++;
      end
      if (flashWeN && !prevWeN)
        check(weLow == WE_CYC, "R3", "we low width", weLow, WE_CYC);
      if (flashOeN && !prevOeN)
        check(oeLow == RD_CYC, "R5", "oe low width", oeLow, RD_CYC);
      if (flashRstN && !prevRstN)
        check(rstLow == RST_CYC, "R7", "reset low width", rstLow, RST_CYC);
      if (doneP || failP)
        check(!prevRstN, doneP ? "R7" : "R8", "pulse right after reset", prevRstN, 0);
      weLow   = flashWeN ? 0 : weLow + 1;
      oeLow   = flashOeN ? 0 : oeLow + 1;
      rstLow  = flashRstN ? 0 : rstLow + 1;
      gapHigh = flashWeN ? gapHigh + 1 : 0;
    end
    prevWeN = flashWeN; prevOeN = flashOeN; prevRstN = flashRstN;
  end

  // driver: pushes expected writes, starts the op, waits for its outcome
  task automatic runOp(input logic [SECT_W-1:0] sec, input int need,
                       input bit intrude, input bit startAtEnd);
    logic [ADDR_W-1:0] a;
    int tries, guard;
    bit expPass, sawDone, sawFail;
    a = (ADDR_W'(sec) << SECT_LSB) | ADDR_W'(2);
    needProt = need; protCount = 0; writeIdx = 0;
    expPass = (need <= MAX_TRY);
    tries = expPass ? need : MAX_TRY;
    expQ.push_back('{addr: a, data: 16'h0060});
    for (int t = 0; t < tries; t++) begin
      expQ.push_back('{addr: a, data: 16'h0060});
      expQ.push_back('{addr: a, data: 16'h0040});
    end
    @(negedge clk); sectorIn = sec; startReq = 1;
    @(negedge clk); startReq = 0;
    check(busy == 1, "R9", "busy after start", busy, 1);
    if (intrude) begin
      repeat (4) @(negedge clk);
      sectorIn = ~sec; startReq = 1;
      @(negedge clk); startReq = 0; sectorIn = sec;
    end
    guard = 0; sawDone = 0; sawFail = 0;
    while (!(doneP || failP) && guard < 2000) begin
      @(negedge clk); guard++;
    end
    sawDone = doneP; sawFail = failP;
    check(busy == 1, "R9", "busy during pulse", busy, 1);
    if (startAtEnd) startReq = 1;
    check(sawDone == expPass, expPass ? "R7" : "R8", "done pulse", sawDone, expPass);
    check(sawFail == !expPass, expPass ? "R6" : "R8", "fail pulse", sawFail, !expPass);
    check(protCount == tries, "R6", "protect write count", protCount, tries);
    @(negedge clk); startReq = 0;
    check(!doneP && !failP, "R7", "pulse one cycle", {doneP, failP}, 0);
    if (startAtEnd) begin
      for (int i = 0; i < 12; i++) begin
        check(!busy && flashWeN, "R9", "start in pulse cycle ignored", busy, 0);
        @(negedge clk);
      end
    end
    check(expQ.size() == 0, "R2", "all writes seen", expQ.size(), 0);
    expQ.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !doneP && !failP, "R1", "status in reset", {busy, doneP, failP}, 0);
    check(flashWeN && flashOeN && flashRstN, "R1", "strobes in reset",
          {flashWeN, flashOeN, flashRstN}, 3'b111);
    rstN = 1;
    @(negedge clk);
    check(!busy && flashWeN && flashOeN && flashRstN, "R1", "idle after reset",
          {busy, flashWeN, flashOeN, flashRstN}, 4'b0111);
    runOp(7'h15, 1, 0, 0);        // R2 first try passes
    runOp(7'h7F, MAX_TRY, 0, 0);  // R6 passes on last allowed try
    runOp(7'h00, 99, 0, 0);       // R8 never confirmed
    runOp(7'h2A, 2, 1, 0);        // R9 start while busy
    runOp(7'h33, 1, 0, 1);        // R9 start in the done cycle
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule